// File: doc/BRIEF.md
# Two-Level I/O Device Selector

This block widens the 4-bit device field of the processor's I/O instructions into a 256-entry device space. During an I/O transfer cycle, the block decodes the device field into sixteen single-clock strobes. The strobe for device field 0 loads the data-bus byte into an 8-bit select register. That register is decoded into 256 one-hot device-select lines.

Software first issues an I/O instruction with device field 0 to pick a device. Later I/O instructions with device fields 1 to 7 then reach only the chosen device, through its own transfer strobe. Device fields 8 to 15 still produce their plain strobes, but they do not drive the per-device transfer lines. The behaviour of the devices themselves lies outside this block.

Top module: `io_expander`

## Requirements
- R1: When `instr_grp` equals 6, `state_code` equals 2'b10 (bit 1 high, bit 0 low) and `io_pulse` is high, `n_stb` is one-hot in the same cycle, with bit `dev_field` set.
- R2: `n_stb` is all zero whenever `instr_grp` is not 6, `state_code` is not 2'b10, or `io_pulse` is low.
- R3: On a clock edge where `n_stb[0]` is high, `sel_q` takes the value of `data_bus`, and the new value is visible after that edge.
- R4: On every other clock edge, `sel_q` holds its value. This includes I/O cycles whose device field is not 0, and the data-bus value has no effect on it.
- R5: `dev_sel` is always one-hot, with bit `sel_q` set.
- R6: In the same cycle, `dev_xfer` equals `dev_sel` when any of `n_stb[7:1]` is high. It is all zero otherwise, which includes cycles where only `n_stb[0]` or only one of `n_stb[15:8]` is high.
- R7: The synchronous active-high `rst` clears `sel_q` to 0, so that `dev_sel[0]` is high. Reset takes priority over a load in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_grp | input | 4 | Instruction group field of the current instruction |
| dev_field | input | 4 | Device field of the current instruction |
| state_code | input | 2 | Machine state code; 2'b10 marks an I/O transfer cycle |
| io_pulse | input | 1 | One-clock timing pulse of the cycle that qualifies strobes |
| data_bus | input | 8 | Data bus byte |
| n_stb | output | 16 | Decoded device-field strobes |
| sel_q | output | 8 | Current device-select register value |
| dev_sel | output | 256 | One-hot decoded device-select lines |
| dev_xfer | output | 256 | Per-device transfer strobes (select AND device fields 1 to 7) |

## Verification
The strobes `n_stb` and `dev_xfer` are combinational, so they are due in the same cycle as the stimulus. The bench therefore drives inputs on the falling edge and samples these outputs 1 ns later, well before the next rising edge. The register `sel_q` and the decoded `dev_sel` change only after the rising edge that follows a qualified device-field-0 strobe. The bench samples them 1 ns after that edge. For `dev_xfer`, it uses the select value from before the edge as the expected value.

// File: rtl/io_expander_pkg.sv
package io_expander_pkg;
    localparam int DEV_FIELD_W = 4;
    localparam int SEL_W       = 8;
    localparam int GRP_W       = 4;
    localparam int NUM_NSTB    = 2 ** DEV_FIELD_W;
    localparam int NUM_DEV     = 2 ** SEL_W;
    localparam logic [GRP_W-1:0] IO_GROUP   = 4'd6;
    localparam logic [1:0]       IO_STATE   = 2'b10;
    localparam int               XFER_FIRST = 1;
    localparam int               XFER_LAST  = 7;

    typedef struct packed {
        logic [GRP_W-1:0]       grp;
        logic [DEV_FIELD_W-1:0] field;
        logic [1:0]             state;
        logic                   pulse;
    } io_ctl_t;

    function automatic logic io_qualified(input io_ctl_t c);
        return (c.grp == IO_GROUP) && (c.state == IO_STATE) && c.pulse;
    endfunction
endpackage

// File: rtl/io_strobe_dec.sv
module io_strobe_dec
    import io_expander_pkg::*;
#(
    parameter int FIELD_W = DEV_FIELD_W,
    localparam int NSTB   = 2 ** FIELD_W
) (
    input  io_ctl_t           ctl,
    output logic [NSTB-1:0]   stb
);
    logic qual;
    assign qual = io_qualified(ctl);

    for (genvar k = 0; k < NSTB; k++) begin : g_stb
        assign stb[k] = qual && (ctl.field == FIELD_W'(k));
    end
endmodule

// File: rtl/io_sel_reg.sv
module io_sel_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] din,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)       q <= '0;
        else if (load) q <= din;
    end
endmodule

// File: rtl/io_dev_dec.sv
module io_dev_dec #(
    parameter int W   = 8,
    localparam int ND = 2 ** W
) (
    input  logic [W-1:0]  sel,
    input  logic          xfer_any,
    output logic [ND-1:0] onehot,
    output logic [ND-1:0] xfer
);
    for (genvar d = 0; d < ND; d++) begin : g_dev
        assign onehot[d] = (sel == W'(d));
        assign xfer[d]   = onehot[d] && xfer_any;
    end
endmodule

// File: rtl/io_expander.sv
module io_expander
    import io_expander_pkg::*;
#(
    parameter int FIELD_W = DEV_FIELD_W,
    parameter int SW      = SEL_W,
    localparam int NSTB   = 2 ** FIELD_W,
    localparam int NDEV   = 2 ** SW
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [GRP_W-1:0]  instr_grp,
    input  logic [FIELD_W-1:0] dev_field,
    input  logic [1:0]        state_code,
    input  logic              io_pulse,
    input  logic [SW-1:0]     data_bus,
    output logic [NSTB-1:0]   n_stb,
    output logic [SW-1:0]     sel_q,
    output logic [NDEV-1:0]   dev_sel,
    output logic [NDEV-1:0]   dev_xfer
);
    io_ctl_t ctl;
    logic    xfer_any;

    always_comb begin
        ctl.grp   = instr_grp;
        ctl.field = dev_field;
        ctl.state = state_code;
        ctl.pulse = io_pulse;
    end

    io_strobe_dec #(.FIELD_W(FIELD_W)) u_stb (
        .ctl (ctl),
        .stb (n_stb)
    );

    io_sel_reg #(.W(SW)) u_reg (
        .clk  (clk),
        .rst  (rst),
        .load (n_stb[0]),
        .din  (data_bus),
        .q    (sel_q)
    );

    assign xfer_any = |n_stb[XFER_LAST:XFER_FIRST];

    io_dev_dec #(.W(SW)) u_dec (
        .sel      (sel_q),
        .xfer_any (xfer_any),
        .onehot   (dev_sel),
        .xfer     (dev_xfer)
    );
endmodule

// File: rtl/io_expander_chk.sv
module io_expander_chk #(
    parameter int FIELD_W = 4,
    parameter int SW      = 8,
    localparam int NSTB   = 2 ** FIELD_W,
    localparam int NDEV   = 2 ** SW
) (
    input logic               clk,
    input logic               rst,
    input logic [3:0]         instr_grp,
    input logic [FIELD_W-1:0] dev_field,
    input logic [1:0]         state_code,
    input logic               io_pulse,
    input logic [SW-1:0]      data_bus,
    input logic [NSTB-1:0]    n_stb,
    input logic [SW-1:0]      sel_q,
    input logic [NDEV-1:0]    dev_sel,
    input logic [NDEV-1:0]    dev_xfer
);
    logic io_ok;
    assign io_ok = (instr_grp == 4'd6) && (state_code == 2'b10) && io_pulse;

    // R1
    strobe_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        io_ok |-> ($onehot(n_stb) && n_stb[dev_field]));

    // R2
    strobe_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !io_ok |-> (n_stb == '0));

    // R3
    sel_load_chk: assert property (@(posedge clk) disable iff (rst)
        n_stb[0] |=> (sel_q == $past(data_bus)));

    // R4
    sel_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !n_stb[0] |=> $stable(sel_q));

    // R5
    dev_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot(dev_sel) && dev_sel[sel_q]);

    // R6
    xfer_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (n_stb[7:1] == '0) |-> (dev_xfer == '0));

    // R6
    xfer_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (n_stb[7:1] != '0) |-> (dev_xfer == dev_sel));

    // R7
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (sel_q == '0));
endmodule

bind io_expander io_expander_chk #(.FIELD_W(FIELD_W), .SW(SW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .instr_grp  (instr_grp),
    .dev_field  (dev_field),
    .state_code (state_code),
    .io_pulse   (io_pulse),
    .data_bus   (data_bus),
    .n_stb      (n_stb),
    .sel_q      (sel_q),
    .dev_sel    (dev_sel),
    .dev_xfer   (dev_xfer)
);

// File: tb/io_expander_bench.sv
`timescale 1ns/1ps
module io_expander_bench;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [3:0]   instr_grp = '0;
    logic [3:0]   dev_field = '0;
    logic [1:0]   state_code = '0;
    logic         io_pulse = 1'b0;
    logic [7:0]   data_bus = '0;
    logic [15:0]  n_stb;
    logic [7:0]   sel_q;
    logic [255:0] dev_sel;
    logic [255:0] dev_xfer;

    int tests = 0;
    int fails = 0;
    bit done  = 0;

    always #2 clk = ~clk;

    io_expander u_io_expander (
        .clk(clk), .rst(rst), .instr_grp(instr_grp), .dev_field(dev_field),
        .state_code(state_code), .io_pulse(io_pulse), .data_bus(data_bus),
        .n_stb(n_stb), .sel_q(sel_q), .dev_sel(dev_sel), .dev_xfer(dev_xfer)
    );

    typedef struct packed {
        logic [3:0]  grp;
        logic [3:0]  fld;
        logic [1:0]  st;
        logic        pl;
        logic [7:0]  d;
        logic [15:0] stb;
        logic [7:0]  sel;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VEC [NV] = '{
        '{4'd6, 4'd0,  2'b10, 1'b1, 8'h5A, 16'h0001, 8'h5A},
        '{4'd6, 4'd1,  2'b10, 1'b1, 8'h33, 16'h0002, 8'h5A},
        '{4'd6, 4'd7,  2'b10, 1'b1, 8'h00, 16'h0080, 8'h5A},
        '{4'd6, 4'd9,  2'b10, 1'b1, 8'h77, 16'h0200, 8'h5A},
        '{4'd6, 4'd15, 2'b10, 1'b1, 8'h12, 16'h8000, 8'h5A},
        '{4'd6, 4'd0,  2'b10, 1'b0, 8'h11, 16'h0000, 8'h5A},
        '{4'd6, 4'd0,  2'b00, 1'b1, 8'h22, 16'h0000, 8'h5A},
        '{4'd6, 4'd0,  2'b11, 1'b1, 8'h23, 16'h0000, 8'h5A},
        '{4'd7, 4'd0,  2'b10, 1'b1, 8'h44, 16'h0000, 8'h5A},
        '{4'd6, 4'd0,  2'b10, 1'b1, 8'hFF, 16'h0001, 8'hFF},
        '{4'd6, 4'd3,  2'b10, 1'b1, 8'h01, 16'h0008, 8'hFF},
        '{4'd6, 4'd0,  2'b10, 1'b1, 8'h00, 16'h0001, 8'h00}
    };

    task automatic check(input string req, input logic [255:0] act, input logic [255:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_sel(input string req, input logic [7:0] exp_sel);
        check(req, 256'(sel_q), 256'(exp_sel));
        check({req, " dev_sel"}, dev_sel, 256'b1 << exp_sel);
    endtask

    // drive at negedge, check combinational outputs, then registered ones after posedge
    task automatic apply(input vec_t v, input logic [7:0] prev_sel);
        logic [255:0] exp_x;
        instr_grp  = v.grp;
        dev_field  = v.fld;
        state_code = v.st;
        io_pulse   = v.pl;
        data_bus   = v.d;
        #1;
        check((v.stb != 0) ? "R1 n_stb" : "R2 n_stb", 256'(n_stb), 256'(v.stb));
        exp_x = (v.stb[7:1] != 0) ? (256'b1 << prev_sel) : '0;
        check("R6 dev_xfer", dev_xfer, exp_x);
        @(posedge clk); #1;
        check_sel((v.stb[0]) ? "R3 sel_q" : "R4 sel_q", v.sel);
        @(negedge clk);
    endtask

    task automatic idle();
        instr_grp = '0; dev_field = '0; state_code = '0; io_pulse = 0; data_bus = '0;
    endtask

    initial begin
        logic [7:0] prev;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        #1;
        check_sel("R7 reset state", 8'h00);
        check("R2 n_stb idle", 256'(n_stb), '0);

        prev = 8'h00;
        for (int k = 0; k < NV; k++) begin
            apply(VEC[k], prev);
            prev = VEC[k].sel;
        end

        // R4: long idle with a busy data bus leaves sel untouched
        idle();
        data_bus = 8'hC3;
        repeat (4) @(posedge clk);
        #1;
        check_sel("R4 hold idle", 8'h00);
        @(negedge clk);

        // R5: highest device index
        apply('{4'd6, 4'd0, 2'b10, 1'b1, 8'hFF, 16'h0001, 8'hFF}, 8'h00);
        apply('{4'd6, 4'd5, 2'b10, 1'b1, 8'h00, 16'h0020, 8'hFF}, 8'hFF);
        apply('{4'd6, 4'd8, 2'b10, 1'b1, 8'h00, 16'h0100, 8'hFF}, 8'hFF);

        // R7: reset beats a simultaneous load
        rst = 1;
        instr_grp = 4'd6; dev_field = 4'd0; state_code = 2'b10; io_pulse = 1; data_bus = 8'h3C;
        @(posedge clk); #1;
        check_sel("R7 reset priority", 8'h00);
        @(negedge clk);
        rst = 0;
        idle();
        #1;
        check("R6 dev_xfer idle after reset", dev_xfer, '0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule